// File: doc/BRIEF.md
# Accelerator Control and Debug Register Block

This block is the configuration and debug register file of a compute accelerator. Software reaches it through a word-indexed register port: a write enable, a 4-bit word index, 32-bit write data and a combinational 32-bit read value. It holds two DRAM windows. Each window has a base offset counted in 64 KiB blocks and a 4-bit cache attribute that goes unchanged to the AXI converter of that window.

The same register file also runs debug logic that watches the instruction decoder:
- a stall watchdog raises a flag when the decoder state has stayed unchanged for a programmed number of cycles;
- a program counter advances on every instruction-complete pulse;
- a comparator raises a tracepoint flag while that counter equals a programmed value;
- a periodic sampler captures the program counter and the decoder handshake lines at a programmable interval and marks each capture with a one-cycle strobe.

These flags and strobes are meant to trigger an external logic analyser.

Top module: `accel_dbg_regs`

## Requirements
- R1: After a synchronous reset, the registers hold these values: both offsets 0, both cache attributes 0, timeout 100 (0x64), tracepoint 0xFFFFFFFF, program counter 0, sample interval 0. All output flags and the strobe are low.
- R2: Offset registers sit at index 0x0 (window 0) and 0x4 (window 1). Each is 32 bits and reads back in full. The byte base output is the register value shifted left by 16 and kept to 32 bits, so a value of 1 gives 0x00010000.
- R3: Cache attribute registers sit at index 0x1 (window 0) and 0x5 (window 1). Each stores write-data bits 3:0 and drives them unchanged to its cache output. Read bits 31:4 are zero.
- R4: Indices 0x2, 0x3, 0x6, 0x7 and 0xC to 0xF read as zero. Writes to them change no register and no output.
- R5: The timeout register (index 0x8) and the sample interval register (index 0xB) store write-data bits 15:0. Read bits 31:16 are zero.
- R6: A stall count is the number of consecutive clock edges at which the decoder state equals its value at the previous edge, saturating at 0xFFFF. The timeout flag is high exactly when the count is nonzero and at least the timeout register value.
- R7: A clock edge at which the decoder state differs from its previous value clears the stall count, so the timeout flag is low after it.
- R8: The program counter (index 0xA, 32 bits, wrapping) increases by one at each edge where the instruction-complete input is high.
- R9: A write to index 0xA loads the program counter. It takes priority over a completion pulse in the same cycle.
- R10: The tracepoint register sits at index 0x9. The tracepoint flag is a level that is high only while the program counter equals the tracepoint register.
- R11: With a nonzero interval N, the sampler strobes once every N edges. It captures the program counter and the handshake lines as they were just before the capturing edge. The first strobe comes N edges after the interval write. The strobe lasts one cycle per capture.
- R12: An interval of 0 keeps the strobe low. Any write to index 0xB restarts the period count and holds the strobe low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_idx | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_idx |
| dec_state | input | 4 | Decoder state being watched |
| dec_hs | input | 4 | Decoder handshake lines to sample |
| instr_done | input | 1 | Instruction-complete pulse |
| dram0_base | output | 32 | Window 0 byte base address |
| dram0_cache | output | 4 | Window 0 AxCACHE value |
| dram1_base | output | 32 | Window 1 byte base address |
| dram1_cache | output | 4 | Window 1 AxCACHE value |
| timeout_flag | output | 1 | Decoder stall flag |
| trace_flag | output | 1 | Program counter match flag |
| sample_valid | output | 1 | One-cycle capture strobe |
| sample_pc | output | 32 | Captured program counter |
| sample_hs | output | 4 | Captured handshake lines |

## Verification
The assertions assume the following about the inputs:
- reg_we, reg_idx, reg_wdata, dec_state and instr_done hold known values at every clock edge outside reset;
- software does not write the program counter during reset.

The bench drives every input only one nanosecond after a rising edge and keeps reg_we low through reset, so both conditions hold. The stimulus is shaped so the rare events do occur:
- the decoder state changes rarely, so stalls grow long enough to trip small timeout values;
- tracepoint writes aim near the live counter, so matches occur;
- interval writes stay below eight, including zero.

// File: rtl/accel_dbg_pkg.sv
package accel_dbg_pkg;

    localparam int REG_IDX_W  = 4;
    localparam int REG_DATA_W = 32;

    typedef logic [REG_IDX_W-1:0]  reg_idx_t;
    typedef logic [REG_DATA_W-1:0] reg_word_t;

    typedef enum logic [REG_IDX_W-1:0] {
        SEL_WIN0_OFS   = 4'h0,
        SEL_WIN0_CACHE = 4'h1,
        SEL_WIN1_OFS   = 4'h4,
        SEL_WIN1_CACHE = 4'h5,
        SEL_STALL_LIM  = 4'h8,
        SEL_TRACE      = 4'h9,
        SEL_PC         = 4'hA,
        SEL_INTERVAL   = 4'hB
    } reg_sel_e;

    typedef struct packed {
        logic      en;
        reg_idx_t  idx;
        reg_word_t data;
    } reg_wr_t;

    localparam int        WIN_STRIDE  = 4;
    localparam reg_word_t TRACE_INIT  = '1;
    localparam int        STALL_INIT  = 100;

    function automatic logic wr_hits(reg_wr_t w, reg_idx_t sel);
        return w.en && (w.idx == sel);
    endfunction

    function automatic reg_word_t zext_word(logic [REG_DATA_W-1:0] v, int width);
        reg_word_t mask;
        mask = (width >= REG_DATA_W) ? '1 : ((reg_word_t'(1) << width) - reg_word_t'(1));
        return v & mask;
    endfunction

endpackage

// File: rtl/dbg_cfg_store.sv
module dbg_cfg_store
    import accel_dbg_pkg::*;
#(
    parameter int NUM_WIN  = 2,
    parameter int CACHE_W  = 4,
    parameter int STALL_W  = 16,
    parameter int INTVL_W  = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  reg_wr_t                           wr,
    output reg_word_t [NUM_WIN-1:0]           win_ofs,
    output logic [NUM_WIN-1:0][CACHE_W-1:0]   win_cache,
    output logic [STALL_W-1:0]                stall_lim,
    output reg_word_t                         trace_val
);

    genvar n;
    generate
        for (n = 0; n < NUM_WIN; n++) begin : g_win
            localparam reg_idx_t OFS_SEL   = reg_idx_t'(n * WIN_STRIDE);
            localparam reg_idx_t CACHE_SEL = reg_idx_t'(n * WIN_STRIDE + 1);

            always_ff @(posedge clk) begin
                if (rst) begin
                    win_ofs[n]   <= '0;
                    win_cache[n] <= '0;
                end else begin
                    if (wr_hits(wr, OFS_SEL))
                        win_ofs[n] <= wr.data;
                    if (wr_hits(wr, CACHE_SEL))
                        win_cache[n] <= wr.data[CACHE_W-1:0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_lim <= STALL_W'(STALL_INIT);
            trace_val <= TRACE_INIT;
        end else begin
            if (wr_hits(wr, SEL_STALL_LIM))
                stall_lim <= wr.data[STALL_W-1:0];
            if (wr_hits(wr, SEL_TRACE))
                trace_val <= wr.data;
        end
    end

    // R3
    cache_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_hits(wr, reg_idx_t'(1)) |=> $stable(win_cache[0]));

endmodule

// File: rtl/dbg_stall_watch.sv
module dbg_stall_watch #(
    parameter int STATE_W = 4,
    parameter int STALL_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] dec_state,
    input  logic [STALL_W-1:0] stall_lim,
    output logic               timeout_flag
);

    localparam logic [STALL_W-1:0] CNT_MAX = '1;

    logic [STATE_W-1:0] state_q;
    logic [STALL_W-1:0] run_q;
    logic [STALL_W-1:0] run_nxt;
    logic               unchanged;

    assign unchanged = (dec_state == state_q);

    always_comb begin
        if (!unchanged)
            run_nxt = '0;
        else if (run_q == CNT_MAX)
            run_nxt = run_q;
        else
            run_nxt = run_q + STALL_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            run_q   <= '0;
        end else begin
            state_q <= dec_state;
            run_q   <= run_nxt;
        end
    end

    assign timeout_flag = (run_q != '0) && (run_q >= stall_lim);

    // R7
    change_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_state != state_q) |=> !timeout_flag);

    // R6
    run_step_chk: assert property (@(posedge clk) disable iff (rst)
        (unchanged && run_q != CNT_MAX) |=> (run_q == $past(run_q) + STALL_W'(1)));

endmodule

// File: rtl/dbg_pc_track.sv
module dbg_pc_track
    import accel_dbg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  reg_wr_t   wr,
    input  logic      instr_done,
    input  reg_word_t trace_val,
    output reg_word_t pc_q,
    output logic      trace_hit
);

    logic pc_wr;

    assign pc_wr = wr_hits(wr, SEL_PC);

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (pc_wr)
            pc_q <= wr.data;
        else if (instr_done)
            pc_q <= pc_q + reg_word_t'(1);
    end

    assign trace_hit = (pc_q == trace_val);

    // R9
    pc_load_chk: assert property (@(posedge clk) disable iff (rst)
        pc_wr |=> (pc_q == $past(wr.data)));

    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && instr_done) |=> (pc_q == $past(pc_q) + reg_word_t'(1)));

    // R8
    pc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && !instr_done) |=> $stable(pc_q));

endmodule

// File: rtl/dbg_sampler.sv
module dbg_sampler
    import accel_dbg_pkg::*;
#(
    parameter int INTVL_W = 16,
    parameter int HS_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr,
    input  reg_word_t         pc_now,
    input  logic [HS_W-1:0]   dec_hs,
    output logic [INTVL_W-1:0] interval_q,
    output logic              sample_valid,
    output reg_word_t         sample_pc,
    output logic [HS_W-1:0]   sample_hs
);

    logic [INTVL_W-1:0] phase_q;
    logic               intvl_wr;
    logic               period_end;

    assign intvl_wr   = wr_hits(wr, SEL_INTERVAL);
    assign period_end = (interval_q != '0) && (phase_q == interval_q - INTVL_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            interval_q   <= '0;
            phase_q      <= '0;
            sample_valid <= 1'b0;
            sample_pc    <= '0;
            sample_hs    <= '0;
        end else if (intvl_wr) begin
            interval_q   <= wr.data[INTVL_W-1:0];
            phase_q      <= '0;
            sample_valid <= 1'b0;
        end else if (interval_q == '0) begin
            phase_q      <= '0;
            sample_valid <= 1'b0;
        end else if (period_end) begin
            phase_q      <= '0;
            sample_valid <= 1'b1;
            sample_pc    <= pc_now;
            sample_hs    <= dec_hs;
        end else begin
            phase_q      <= phase_q + INTVL_W'(1);
            sample_valid <= 1'b0;
        end
    end

    // R12
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        intvl_wr |=> !sample_valid);

    // R11
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && interval_q > INTVL_W'(1) && !intvl_wr) |=> !sample_valid);

    // R12
    zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (interval_q == '0 && !intvl_wr) |=> !sample_valid);

endmodule

// File: rtl/accel_dbg_regs.sv
module accel_dbg_regs
    import accel_dbg_pkg::*;
#(
    parameter int CACHE_W   = 4,
    parameter int STALL_W   = 16,
    parameter int INTVL_W   = 16,
    parameter int STATE_W   = 4,
    parameter int HS_W      = 4,
    parameter int BLK_SHIFT = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [REG_IDX_W-1:0]  reg_idx,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    input  logic [STATE_W-1:0]    dec_state,
    input  logic [HS_W-1:0]       dec_hs,
    input  logic                  instr_done,
    output logic [REG_DATA_W-1:0] dram0_base,
    output logic [CACHE_W-1:0]    dram0_cache,
    output logic [REG_DATA_W-1:0] dram1_base,
    output logic [CACHE_W-1:0]    dram1_cache,
    output logic                  timeout_flag,
    output logic                  trace_flag,
    output logic                  sample_valid,
    output logic [REG_DATA_W-1:0] sample_pc,
    output logic [HS_W-1:0]       sample_hs
);

    localparam int NUM_WIN = 2;

    reg_wr_t                             wr;
    reg_word_t [NUM_WIN-1:0]             win_ofs;
    logic [NUM_WIN-1:0][CACHE_W-1:0]     win_cache;
    logic [STALL_W-1:0]                  stall_lim;
    reg_word_t                           trace_val;
    reg_word_t                           pc_q;
    logic [INTVL_W-1:0]                  interval_q;

    assign wr = '{en: reg_we, idx: reg_idx, data: reg_wdata};

    dbg_cfg_store #(
        .NUM_WIN (NUM_WIN),
        .CACHE_W (CACHE_W),
        .STALL_W (STALL_W),
        .INTVL_W (INTVL_W)
    ) cfg_i (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .win_ofs   (win_ofs),
        .win_cache (win_cache),
        .stall_lim (stall_lim),
        .trace_val (trace_val)
    );

    dbg_stall_watch #(
        .STATE_W (STATE_W),
        .STALL_W (STALL_W)
    ) stall_i (
        .clk          (clk),
        .rst          (rst),
        .dec_state    (dec_state),
        .stall_lim    (stall_lim),
        .timeout_flag (timeout_flag)
    );

    dbg_pc_track pc_i (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .instr_done (instr_done),
        .trace_val  (trace_val),
        .pc_q       (pc_q),
        .trace_hit  (trace_flag)
    );

    dbg_sampler #(
        .INTVL_W (INTVL_W),
        .HS_W    (HS_W)
    ) smp_i (
        .clk          (clk),
        .rst          (rst),
        .wr           (wr),
        .pc_now       (pc_q),
        .dec_hs       (dec_hs),
        .interval_q   (interval_q),
        .sample_valid (sample_valid),
        .sample_pc    (sample_pc),
        .sample_hs    (sample_hs)
    );

    assign dram0_base  = REG_DATA_W'(win_ofs[0] << BLK_SHIFT);
    assign dram1_base  = REG_DATA_W'(win_ofs[1] << BLK_SHIFT);
    assign dram0_cache = win_cache[0];
    assign dram1_cache = win_cache[1];

    always_comb begin
        reg_rdata = '0;
        case (reg_idx)
            SEL_WIN0_OFS:   reg_rdata = win_ofs[0];
            SEL_WIN0_CACHE: reg_rdata = zext_word(REG_DATA_W'(win_cache[0]), CACHE_W);
            SEL_WIN1_OFS:   reg_rdata = win_ofs[1];
            SEL_WIN1_CACHE: reg_rdata = zext_word(REG_DATA_W'(win_cache[1]), CACHE_W);
            SEL_STALL_LIM:  reg_rdata = zext_word(REG_DATA_W'(stall_lim), STALL_W);
            SEL_TRACE:      reg_rdata = trace_val;
            SEL_PC:         reg_rdata = pc_q;
            SEL_INTERVAL:   reg_rdata = zext_word(REG_DATA_W'(interval_q), INTVL_W);
            default:        reg_rdata = '0;
        endcase
    end

    // R2
    base_track_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_idx == 4'h0) |=> (dram0_base[REG_DATA_W-1:BLK_SHIFT] ==
                                          $past(reg_wdata[REG_DATA_W-BLK_SHIFT-1:0])));

endmodule

// File: tb/accel_dbg_regs_tb_top.sv
`timescale 1ns/1ps
module accel_dbg_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [3:0]  reg_idx;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [3:0]  dec_state;
    logic [3:0]  dec_hs;
    logic        instr_done;
    logic [31:0] dram0_base, dram1_base, sample_pc;
    logic [3:0]  dram0_cache, dram1_cache, sample_hs;
    logic        timeout_flag, trace_flag, sample_valid;

    always #2 clk = ~clk;

    accel_dbg_regs dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dec_state(dec_state),
        .dec_hs(dec_hs), .instr_done(instr_done), .dram0_base(dram0_base),
        .dram0_cache(dram0_cache), .dram1_base(dram1_base), .dram1_cache(dram1_cache),
        .timeout_flag(timeout_flag), .trace_flag(trace_flag),
        .sample_valid(sample_valid), .sample_pc(sample_pc), .sample_hs(sample_hs)
    );

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [31:0] m_ofs0, m_ofs1, m_trace, m_pc, m_spc;
    logic [3:0]  m_c0, m_c1, m_st, m_shs;
    logic [15:0] m_lim, m_int, m_ph, m_run;
    logic        m_val, m_changed;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [3:0] idx);
        case (idx)
            4'h0: return m_ofs0;
            4'h1: return {28'h0, m_c0};
            4'h4: return m_ofs1;
            4'h5: return {28'h0, m_c1};
            4'h8: return {16'h0, m_lim};
            4'h9: return m_trace;
            4'hA: return m_pc;
            4'hB: return {16'h0, m_int};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [3:0] idx);
        case (idx)
            4'h0, 4'h4: return "R2 offset read";
            4'h1, 4'h5: return "R3 cache read";
            4'h8, 4'hB: return "R5 narrow read";
            4'h9:       return "R10 tracepoint read";
            4'hA:       return "R8 pc read";
            default:    return "R4 unused read";
        endcase
    endfunction

    task automatic model_reset();
        m_ofs0 = 0; m_ofs1 = 0; m_c0 = 0; m_c1 = 0; m_lim = 16'd100;
        m_trace = 32'hFFFFFFFF; m_pc = 0; m_int = 0; m_ph = 0; m_val = 0;
        m_st = 0; m_run = 0; m_changed = 0;
    endtask

    task automatic model_edge();
        logic wr;
        wr = reg_we;
        m_changed = (dec_state != m_st);
        if (m_changed) m_run = 0;
        else if (m_run != 16'hFFFF) m_run = m_run + 1;
        m_st = dec_state;
        if (wr && reg_idx == 4'hB) begin
            m_int = reg_wdata[15:0]; m_ph = 0; m_val = 0;
        end else if (m_int == 0) begin
            m_ph = 0; m_val = 0;
        end else if (m_ph == m_int - 1) begin
            m_ph = 0; m_val = 1; m_spc = m_pc; m_shs = dec_hs;
        end else begin
            m_ph = m_ph + 1; m_val = 0;
        end
        if (wr && reg_idx == 4'hA) m_pc = reg_wdata;
        else if (instr_done) m_pc = m_pc + 1;
        if (wr) begin
            case (reg_idx)
                4'h0: m_ofs0 = reg_wdata;
                4'h1: m_c0 = reg_wdata[3:0];
                4'h4: m_ofs1 = reg_wdata;
                4'h5: m_c1 = reg_wdata[3:0];
                4'h8: m_lim = reg_wdata[15:0];
                4'h9: m_trace = reg_wdata;
                default: ;
            endcase
        end
    endtask

    task automatic check_outputs();
        logic ef;
        ef = (m_run != 0) && (m_run >= m_lim);
        chk(dram0_base == (m_ofs0 << 16), "R2 dram0 base", dram0_base, m_ofs0 << 16);
        chk(dram1_base == (m_ofs1 << 16), "R2 dram1 base", dram1_base, m_ofs1 << 16);
        chk(dram0_cache == m_c0, "R3 dram0 cache", {28'h0, dram0_cache}, {28'h0, m_c0});
        chk(dram1_cache == m_c1, "R3 dram1 cache", {28'h0, dram1_cache}, {28'h0, m_c1});
        chk(timeout_flag == ef, m_changed ? "R7 timeout clear" : "R6 timeout flag",
            {31'h0, timeout_flag}, {31'h0, ef});
        chk(trace_flag == (m_pc == m_trace), "R10 trace flag", {31'h0, trace_flag}, {31'h0, m_pc == m_trace});
        chk(sample_valid == m_val, (m_int == 0) ? "R12 strobe idle" : "R11 strobe",
            {31'h0, sample_valid}, {31'h0, m_val});
        if (m_val) begin
            chk(sample_pc == m_spc, "R11 sample pc", sample_pc, m_spc);
            chk(sample_hs == m_shs, "R11 sample hs", {28'h0, sample_hs}, {28'h0, m_shs});
        end
        chk(reg_rdata == exp_read(reg_idx), read_tag(reg_idx), reg_rdata, exp_read(reg_idx));
    endtask

    // One clock: model follows the edge, outputs compared 1 ns later.
    task automatic step();
        @(posedge clk);
        if (rst) model_reset(); else model_edge();
        #1;
        check_outputs();
    endtask

    task automatic drive(input logic we, input logic [3:0] idx, input logic [31:0] d,
                         input logic [3:0] st, input logic done);
        reg_we = we; reg_idx = idx; reg_wdata = d; dec_state = st; instr_done = done;
        dec_hs = 4'($urandom);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        rst = 1'b1;
        drive(0, 4'h0, 0, 4'h0, 0);
        repeat (3) step();
        #0 rst = 1'b0;

        // R1: reset values read back through every index
        for (int i = 0; i < 16; i++) begin
            drive(0, 4'(i), 0, 4'h0, 0);
            #1;
            chk(reg_rdata == exp_read(4'(i)), "R1 reset read", reg_rdata, exp_read(4'(i)));
        end
        chk(!sample_valid && !trace_flag, "R1 reset flags", {30'h0, sample_valid, trace_flag}, 32'h0);

        // R2: one block gives 0x00010000
        drive(1, 4'h0, 32'h1, 4'h1, 0); step();
        chk(dram0_base == 32'h0001_0000, "R2 single block", dram0_base, 32'h0001_0000);
        // R4: unused write has no effect
        drive(1, 4'h2, 32'hDEAD_BEEF, 4'h1, 0); step();
        drive(0, 4'h2, 0, 4'h1, 0); step();
        chk(reg_rdata == 0, "R4 unused write ignored", reg_rdata, 0);
        // R5: narrow truncation
        drive(1, 4'h8, 32'hABCD_0003, 4'h1, 0); step();
        drive(0, 4'h8, 0, 4'h1, 0); step();
        chk(reg_rdata == 32'h3, "R5 timeout width", reg_rdata, 32'h3);
        // R6: stall with limit 3
        repeat (4) begin drive(0, 4'h8, 0, 4'h1, 0); step(); end
        chk(timeout_flag == 1'b1, "R6 stall trips", {31'h0, timeout_flag}, 1);
        drive(0, 4'h8, 0, 4'h2, 0); step();
        chk(timeout_flag == 1'b0, "R7 state change clears", {31'h0, timeout_flag}, 0);
        // R9: write beats completion
        drive(1, 4'hA, 32'h50, 4'h2, 1); step();
        chk(m_pc == 32'h50 && reg_rdata == exp_read(reg_idx), "R9 write priority", m_pc, 32'h50);
        // R8 and R10: count to tracepoint
        drive(1, 4'h9, 32'h52, 4'h2, 1); step();
        drive(0, 4'hA, 0, 4'h2, 1); step();
        chk(trace_flag == 1'b1, "R10 trace hit", {31'h0, trace_flag}, 1);
        drive(0, 4'hA, 0, 4'h2, 1); step();
        chk(trace_flag == 1'b0, "R10 trace level drops", {31'h0, trace_flag}, 0);
        // R11: interval 3
        drive(1, 4'hB, 32'h3, 4'h2, 0); step();
        for (int k = 1; k <= 6; k++) begin
            drive(0, 4'hB, 0, 4'h2, 0); step();
            chk(sample_valid == (k % 3 == 0), "R11 period three", {31'h0, sample_valid}, {31'h0, k % 3 == 0});
        end
        // R12: zero disables
        drive(1, 4'hB, 32'h0, 4'h2, 0); step();
        repeat (5) begin drive(0, 4'hB, 0, 4'h2, 0); step(); end

        // Constrained random phase
        for (int n = 0; n < 4000; n++) begin
            logic        we;
            logic [3:0]  idx, st;
            logic [31:0] d;
            we  = ($urandom % 4) == 0;
            idx = 4'($urandom);
            d   = $urandom;
            case (idx)
                4'h8: d = $urandom % 24;
                4'h9: d = m_pc + ($urandom % 4);
                4'hA: d = $urandom % 64;
                4'hB: d = $urandom % 8;
                default: ;
            endcase
            st = (($urandom % 16) == 0) ? 4'($urandom) : m_st;
            drive(we, idx, d, st, ($urandom % 3) == 0);
            step();
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule